// File: doc/BRIEF.md
# Peripheral Clock Gate and Reset Sequencer

This block owns a bank of per-peripheral clock-enable levels and the peripheral reset lines that go with them. A request names one channel and asks for its clock to be turned on or off. A channel can be tied to one reset line, or to none. Turning on a channel that has a reset line runs a timed sequence. First the reset is put on. After a settle delay the clock starts. After a longer delay the reset is taken off. Turning off a channel only stops its clock.

A status vector reports which channels are up. A channel whose reset is held never counts as up, even when its clock bit says it is running. Both delays are counted in reference-clock cycles, so they can be scaled to the real clock and shortened for simulation. Only one request is served at a time. While a timed sequence runs, the block raises busy and ignores new requests. Every request that is accepted ends with a one-cycle done pulse.

The gate outputs form a stop-control vector. A 1 stops the clock on every channel except one designated channel, where a 1 means the clock runs.

Top module: `clk_gate_rst_seq`

## Requirements
- R1: An enable request on a channel that has a reset line puts that line on at the clock edge that accepts the request. The channel's clock starts exactly PRE_CYC cycles after that edge, and the reset is still on at that moment.
- R2: The reset line is taken off exactly POST_CYC cycles after the clock starts. reqDone pulses for one cycle as it comes off, and busy drops in the same cycle.
- R3: An enable request on a channel without a reset line starts its clock at the accepting edge. reqDone is high in the next cycle and busy stays low.
- R4: chanOn reads 0 for any channel whose reset line is on, whatever its gate bit says.
- R5: An enable request on a channel that chanOn already reports as on pulses reqDone in the next cycle and changes no gate bit and no reset line.
- R6: A disable request stops the channel's clock at the accepting edge, pulses reqDone in the next cycle, and leaves every reset line unchanged.
- R7: In gateStop, a 1 means "clock stopped" for every channel except channel INV_CH (default 14), where a 1 means "clock running".
- R8: A request presented while reqBusy is high is ignored. It changes no output and is not queued.
- R9: After synchronous reset, every reset line used by some channel is on, every clock is stopped in its own polarity, chanOn is all zero, and reqBusy and reqDone are low.
- R10: With the default map, channel i uses reset line i when i mod 4 is not 3. Channels with i mod 4 equal to 3 have no reset line. An entry of NUM_RST or more marks "no reset".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe, sampled when not busy |
| reqEnable | input | 1 | 1 = start the channel, 0 = stop it |
| reqChan | input | 5 | Channel index of the request |
| reqBusy | output | 1 | High while a timed sequence runs |
| reqDone | output | 1 | One-cycle completion pulse |
| chanOn | output | NUM_CH | Per-channel "enabled" status |
| gateStop | output | NUM_CH | Stop-control vector, polarity per R7 |
| periphRst | output | NUM_RST | Peripheral reset lines, 1 = held |

## Verification
The assertions assume four things about the inputs. Reset is applied before the first request. reqChan is always below NUM_CH. Each reset line is used by at most one channel, so no other request can release a line in the middle of a sequence. The bench keeps to this. It draws only legal channel indices and relies on the default one-to-one map. It drives every request on the falling edge and holds it for exactly one rising edge. When it tests refusal, it presents its one extra request while a sequence is in flight. The random part mixes enables and disables over all channels, so the already-on, no-reset and reset-paired paths all come up many times.

// File: rtl/cgr_pkg.sv
package cgr_pkg;
  localparam int MAX_CH  = 32;
  localparam int MAX_CHW = 5;
  localparam int ENTW    = 8;

  typedef struct packed {
    logic [MAX_CHW-1:0] chan;
    logic               startClk;
    logic               stopClk;
    logic               holdRst;
    logic               freeRst;
  } cgr_strobe_t;

  // Default map: channel i -> reset line i, except every fourth channel has none.
  function automatic logic [MAX_CH*ENTW-1:0] defaultMap();
    logic [MAX_CH*ENTW-1:0] m;
    for (int i = 0; i < MAX_CH; i++) begin
      m[i*ENTW +: ENTW] = ((i % 4) == 3) ? 8'hFF : 8'(i);
    end
    return m;
  endfunction

  // Mask of reset lines referenced by at least one channel.
  function automatic logic [MAX_CH-1:0] usedResets(input logic [MAX_CH*ENTW-1:0] m,
                                                   input int nCh, input int nRst);
    logic [MAX_CH-1:0] u;
    u = '0;
    for (int i = 0; i < nCh; i++) begin
      if (int'(m[i*ENTW +: ENTW]) < nRst) u[m[i*ENTW +: 5]] = 1'b1;
    end
    return u;
  endfunction
endpackage

// File: rtl/cgr_datapath.sv
module cgr_datapath
  import cgr_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int NUM_RST = 32,
  parameter int INV_CH  = 14,
  parameter logic [MAX_CH*ENTW-1:0] RST_MAP = cgr_pkg::defaultMap()
) (
  input  logic               clk,
  input  logic               rst,
  input  cgr_strobe_t        stb,
  output logic [NUM_CH-1:0]  gateStop,
  output logic [NUM_RST-1:0] periphRst,
  output logic [NUM_CH-1:0]  chanOn,
  output logic [NUM_CH-1:0]  chanHasRst
);
  localparam int RW = (NUM_RST > 1) ? $clog2(NUM_RST) : 1;
  localparam logic [MAX_CH-1:0] USED = cgr_pkg::usedResets(RST_MAP, NUM_CH, NUM_RST);

  logic [ENTW-1:0] selEnt;
  logic [RW-1:0]   selIdx;

  always_comb begin
    selEnt = RST_MAP[stb.chan*ENTW +: ENTW];
    selIdx = selEnt[RW-1:0];
  end

  // Per-channel gate bits and status
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ENTW-1:0] ENT = RST_MAP[i*ENTW +: ENTW];
    localparam bit   HAS     = int'(ENT) < NUM_RST;
    localparam logic RUNVAL  = (i == INV_CH) ? 1'b1 : 1'b0;
    localparam logic STOPVAL = ~RUNVAL;

    always_ff @(posedge clk) begin
      if (rst) begin
        gateStop[i] <= STOPVAL;
      end else if (stb.chan == MAX_CHW'(i)) begin
        if (stb.startClk)     gateStop[i] <= RUNVAL;
        else if (stb.stopClk) gateStop[i] <= STOPVAL;
      end
    end

    if (HAS) begin : g_rst
      localparam logic [RW-1:0] IDX = ENT[RW-1:0];
      assign chanHasRst[i] = 1'b1;
      assign chanOn[i]     = (gateStop[i] == RUNVAL) && !periphRst[IDX];
    end else begin : g_norst
      assign chanHasRst[i] = 1'b0;
      assign chanOn[i]     = (gateStop[i] == RUNVAL);
    end
  end

  // Reset lines
  for (genvar j = 0; j < NUM_RST; j++) begin : g_rl
    always_ff @(posedge clk) begin
      if (rst) begin
        periphRst[j] <= USED[j];
      end else if (selIdx == RW'(j) && int'(selEnt) < NUM_RST) begin
        if (stb.holdRst)      periphRst[j] <= 1'b1;
        else if (stb.freeRst) periphRst[j] <= 1'b0;
      end
    end
  end

  AST_CLK_UNDER_RST: assert property (@(posedge clk) disable iff (rst)
    (stb.startClk && chanHasRst[stb.chan]) |-> periphRst[selIdx]) // R1
    else $error("clock started without reset held");

  AST_FREE_WHILE_RUNNING: assert property (@(posedge clk) disable iff (rst)
    stb.freeRst |-> (gateStop[stb.chan] == (stb.chan == MAX_CHW'(INV_CH)))) // R2
    else $error("reset released before clock running");

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.startClk, stb.stopClk, stb.holdRst, stb.freeRst})) // R6
    else $error("conflicting strobes");
endmodule

// File: rtl/cgr_ctrl.sv
module cgr_ctrl
  import cgr_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int PRE_CYC  = 2400,
  parameter int POST_CYC = 240000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic               reqEnable,
  input  logic [MAX_CHW-1:0] reqChan,
  input  logic [NUM_CH-1:0]  chanOn,
  input  logic [NUM_CH-1:0]  chanHasRst,
  output cgr_strobe_t        stb,
  output logic               reqBusy,
  output logic               reqDone
);
  localparam int MAXW = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC;
  localparam int CNTW = $clog2(MAXW + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_POST} state_t;

  state_t             state;
  logic [CNTW-1:0]    cnt;
  logic [MAX_CHW-1:0] curChan;
  logic               accept, seqStart, cntZero;

  assign accept   = (state == ST_IDLE) && reqValid;
  assign seqStart = accept && reqEnable && !chanOn[reqChan] && chanHasRst[reqChan];
  assign cntZero  = (cnt == '0);
  assign reqBusy  = (state != ST_IDLE);

  always_comb begin
    stb      = '0;
    stb.chan = (state == ST_IDLE) ? reqChan : curChan;
    if (accept) begin
      if (!reqEnable)             stb.stopClk  = 1'b1;
      else if (chanOn[reqChan])   stb.stopClk  = 1'b0;
      else if (chanHasRst[reqChan]) stb.holdRst = 1'b1;
      else                        stb.startClk = 1'b1;
    end else if (state == ST_PRE && cntZero) begin
      stb.startClk = 1'b1;
    end else if (state == ST_POST && cntZero) begin
      stb.freeRst = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      curChan <= '0;
      reqDone <= 1'b0;
    end else begin
      reqDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (seqStart) begin
            state   <= ST_PRE;
            cnt     <= CNTW'(PRE_CYC - 1);
            curChan <= reqChan;
          end else if (accept) begin
            reqDone <= 1'b1;
          end
        end
        ST_PRE: begin
          if (cntZero) begin
            state <= ST_POST;
            cnt   <= CNTW'(POST_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_POST: begin
          if (cntZero) begin
            state   <= ST_IDLE;
            reqDone <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    reqBusy |-> !reqDone) // R8
    else $error("done while busy");

  AST_SEQ_STATUS_OFF: assert property (@(posedge clk) disable iff (rst)
    reqBusy |-> !chanOn[curChan]) // R4
    else $error("channel reported on during its sequence");
endmodule

// File: rtl/clk_gate_rst_seq.sv
module clk_gate_rst_seq
  import cgr_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int NUM_RST  = 32,
  parameter int INV_CH   = 14,
  parameter int PRE_CYC  = 2400,
  parameter int POST_CYC = 240000,
  parameter logic [MAX_CH*ENTW-1:0] RST_MAP = cgr_pkg::defaultMap()
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic               reqEnable,
  input  logic [4:0]         reqChan,
  output logic               reqBusy,
  output logic               reqDone,
  output logic [NUM_CH-1:0]  chanOn,
  output logic [NUM_CH-1:0]  gateStop,
  output logic [NUM_RST-1:0] periphRst
);
  cgr_strobe_t       stb;
  logic [NUM_CH-1:0] chanHasRst;

  cgr_ctrl #(.NUM_CH(NUM_CH), .PRE_CYC(PRE_CYC), .POST_CYC(POST_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqEnable(reqEnable),
    .reqChan(reqChan), .chanOn(chanOn), .chanHasRst(chanHasRst),
    .stb(stb), .reqBusy(reqBusy), .reqDone(reqDone)
  );

  cgr_datapath #(.NUM_CH(NUM_CH), .NUM_RST(NUM_RST), .INV_CH(INV_CH),
                 .RST_MAP(RST_MAP)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .gateStop(gateStop),
    .periphRst(periphRst), .chanOn(chanOn), .chanHasRst(chanHasRst)
  );
endmodule

// File: tb/sim_clk_gate_rst_seq.sv
`timescale 1ns/1ps
module sim_clk_gate_rst_seq;
  localparam int NCH  = 32;
  localparam int PRE  = 4;
  localparam int POST = 6;
  localparam int INVC = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqEnable = 1'b0;
  logic [4:0] reqChan = '0;
  logic reqBusy, reqDone;
  logic [NCH-1:0] chanOn, gateStop, periphRst;

  int nChecks = 0, nFails = 0;
  bit expRun [NCH];
  bit expRst [NCH];

  always #2.5 clk = ~clk;

  clk_gate_rst_seq #(.PRE_CYC(PRE), .POST_CYC(POST)) u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqEnable(reqEnable),
    .reqChan(reqChan), .reqBusy(reqBusy), .reqDone(reqDone),
    .chanOn(chanOn), .gateStop(gateStop), .periphRst(periphRst)
  );

  function automatic bit hasRst(int ch);
    return (ch % 4) != 3;  // R10 default map
  endfunction

  function automatic logic [NCH-1:0] expGate();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = (i == INVC) ? expRun[i] : !expRun[i]; // R7
    return v;
  endfunction

  function automatic logic [NCH-1:0] expRstVec();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = expRst[i];
    return v;
  endfunction

  function automatic logic [NCH-1:0] expOn();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = expRun[i] && !(hasRst(i) && expRst[i]); // R4
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk(gateStop == expGate(), {tag, " gate"}, gateStop, expGate());
    chk(periphRst == expRstVec(), {tag, " reset"}, periphRst, expRstVec());
    chk(chanOn == expOn(), {tag, " status"}, chanOn, expOn());
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReq(int ch, bit en);
    bit wasOn;
    wasOn = expOn()[ch];
    reqValid = 1'b1; reqEnable = en; reqChan = 5'(ch);
    cyc();
    reqValid = 1'b0;
    if (!en) begin
      expRun[ch] = 1'b0;
      chk(reqDone == 1'b1, "R6 done", 32'(reqDone), 1);
      checkAll("R6");
    end else if (wasOn) begin
      chk(reqDone == 1'b1, "R5 done", 32'(reqDone), 1);
      checkAll("R5");
    end else if (!hasRst(ch)) begin
      expRun[ch] = 1'b1;
      chk(reqDone && !reqBusy, "R3 done", {reqBusy, reqDone}, 32'b01);
      checkAll("R3");
    end else begin
      expRst[ch] = 1'b1;
      chk(reqBusy == 1'b1, "R1 busy", 32'(reqBusy), 1);
      checkAll("R1");
      repeat (PRE - 1) cyc();
      checkAll("R1 before start");
      cyc();
      expRun[ch] = 1'b1;
      checkAll("R1 started");
      chk(chanOn[ch] == 1'b0, "R4 off while held", 32'(chanOn[ch]), 0);
      repeat (POST - 1) cyc();
      chk(!reqDone && reqBusy, "R2 still held", {reqBusy, reqDone}, 32'b10);
      checkAll("R2 held");
      cyc();
      expRst[ch] = 1'b0;
      chk(reqDone && !reqBusy, "R2 done", {reqBusy, reqDone}, 32'b01);
      checkAll("R2 released");
    end
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < NCH; i++) begin
      expRun[i] = 1'b0;
      expRst[i] = hasRst(i);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc();
    // R9 reset state
    checkAll("R9");
    chk(!reqBusy && !reqDone, "R9 handshake", {reqBusy, reqDone}, 0);
    chk(gateStop[INVC] == 1'b0 && gateStop[0] == 1'b1, "R7 reset polarity",
        {gateStop[INVC], gateStop[0]}, 32'b01);

    doReq(3, 1'b1);   // R3 no-reset channel (R10)
    doReq(0, 1'b1);   // R1 R2 full sequence
    doReq(0, 1'b1);   // R5 already on
    doReq(0, 1'b0);   // R6 disable keeps reset low
    doReq(INVC, 1'b1); // R7 inverted channel
    chk(gateStop[INVC] == 1'b1, "R7 run bit", 32'(gateStop[INVC]), 1);
    doReq(INVC, 1'b0);
    chk(gateStop[INVC] == 1'b0, "R7 stop bit", 32'(gateStop[INVC]), 0);
    doReq(7, 1'b0);   // R6 disable on idle no-reset channel

    // R8: request during a sequence is ignored
    reqValid = 1'b1; reqEnable = 1'b1; reqChan = 5'd1;
    cyc();
    expRst[1] = 1'b1;
    reqChan = 5'd7;
    cyc();
    reqValid = 1'b0;
    checkAll("R8 refused");
    repeat (PRE - 2) cyc();
    cyc();
    expRun[1] = 1'b1;
    repeat (POST) cyc();
    expRst[1] = 1'b0;
    chk(reqDone == 1'b1, "R8 sequence done", 32'(reqDone), 1);
    checkAll("R8 after");
    chk(gateStop[7] == 1'b1, "R8 ch7 untouched", 32'(gateStop[7]), 1);

    // Random mix
    seed = $urandom(32'd4242);
    for (int n = 0; n < 120; n++) begin
      doReq(int'($urandom_range(NCH - 1, 0)), bit'($urandom_range(3, 0) != 0));
      if ($urandom_range(1, 0) == 1) cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule